// File: doc/BRIEF.md
# Decimal Accumulator Shift Unit

This block shifts a twenty-digit packed-BCD accumulator held in sign-magnitude form. It has four operations: a plain right shift, a right shift that rounds, a plain left shift, and a left shift that normalizes. The normalizing shift moves the value up until its top digit is nonzero and then records how far it moved.

The caller places the accumulator, its sign, an operation code and a BCD shift digit on the inputs and pulses `start` for one cycle. The unit copies the operands into a working register and moves them one digit per clock. When the work is finished it presents the new accumulator and sign and raises `done` for a single cycle. The outputs hold that value until the next operation completes. The caller is expected to keep the overflow indication outside the block. No shift changes it.

Top module: `dec_acc_shifter`

## Requirements
- R1: After a synchronous active-low reset, `acc_out` is all zeros, `sign_out` is 0 and `done` is 0.
- R2: `op_sel` selects the operation: 0 plain right, 1 rounding right, 2 plain left, 3 normalize. `start` is accepted only while the unit is idle. `done` is a one-cycle pulse, and `acc_out`/`sign_out` carry the result from that cycle on. Digit i of the accumulator occupies bits 4i+3..4i, so digit 0 is the least significant.
- R3: Plain right shift moves the value down by `shift_digit` places (0 to 9). Digits leaving the bottom are lost, zeros enter at the top, and a digit of 0 leaves the value unchanged.
- R4: Plain left shift moves the value up by `shift_digit` places (0 to 9). Digits leaving the top are lost, zeros enter at the bottom, and a digit of 0 leaves the value unchanged.
- R5: Rounding right shift by n places gives floor(M/10^n), plus one when the last digit shifted out (original digit n-1) is 5 or more. A carry may ripple through any run of nines, and a carry leaving the top digit is dropped. A `shift_digit` of 0 means n = 10.
- R6: Normalize shifts left until digit 19 is nonzero. It then overwrites digit 1 with the tens and digit 0 with the units of the place count, in BCD. A value whose top digit is already nonzero receives a count of 00.
- R7: Normalizing an all-zero magnitude stops after 20 places and gives digit 1 = 2, digit 0 = 0, with every other digit zero.
- R8: `sign_out` equals the `sign_in` captured at `start` for every operation, including results with a zero magnitude.
- R9: A `start` pulse while an operation is in progress is ignored. The result reflects only the operands that were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_sel | input | 2 | Operation code (see R2) |
| shift_digit | input | 4 | BCD place count, 0 to 9 |
| acc_in | input | 80 | Accumulator magnitude, packed BCD |
| sign_in | input | 1 | Accumulator sign, 1 = negative |
| acc_out | output | 80 | Result magnitude, packed BCD |
| sign_out | output | 1 | Result sign |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default width of twenty digits. At that width the normalize count on a zero value reaches 20, which exercises both BCD digits of the count. The rounding shift with a zero digit also travels ten places, so the guard digit comes from the middle of the accumulator. Random operands get a random number of leading zeros, which spreads normalize counts over the whole 0 to 20 range. Directed cases cover long carry ripples through nines, already-normalized values, and a second `start` arriving mid-operation.

// File: rtl/dsu_pkg.sv
// Shared types for the decimal accumulator shift unit.
// Assumes a 2-bit operation code as listed in the brief.
package dsu_pkg;

    typedef enum logic [1:0] {
        OP_SHR      = 2'd0,
        OP_SHR_RND  = 2'd1,
        OP_SHL      = 2'd2,
        OP_SHL_NORM = 2'd3
    } shift_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } shift_state_e;

endpackage

// File: rtl/dsu_bcd_incr.sv
// Adds an optional one to a packed-BCD magnitude through a digit ripple chain.
// Assumes every input digit is a legal BCD value; carry out of the top digit is dropped.
module dsu_bcd_incr #(
    parameter int NDIG = 20
) (
    input  logic [NDIG*4-1:0] mag_in,
    input  logic              cin,
    output logic [NDIG*4-1:0] mag_out
);
    localparam int AW = NDIG * 4;

    logic [NDIG-1:0] carry;

    assign carry[0] = cin;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [3:0] dig;
        assign dig = mag_in[4*g +: 4];
        // Per-digit increment: a nine wraps to zero and passes the carry on.
        assign mag_out[4*g +: 4] = carry[g] ? ((dig == 4'd9) ? 4'd0 : dig + 4'd1) : dig;
        if (g < NDIG - 1) begin : g_chain
            assign carry[g+1] = carry[g] && (dig == 4'd9);
        end
    end

    // Guard against an empty build width at elaboration.
    initial begin
        if (AW < 8) $error("dsu_bcd_incr needs at least two digits");
    end
endmodule

// File: rtl/dsu_count_bcd.sv
// Converts a small binary place count into two BCD digits {tens, units}.
// Assumes the count never exceeds 99.
module dsu_count_bcd #(
    parameter int CW = 5
) (
    input  logic [CW-1:0] count,
    output logic [7:0]    bcd
);
    // Split the count by constant division, small enough to stay shallow.
    always_comb begin
        bcd[7:4] = 4'(int'(count) / 10);
        bcd[3:0] = 4'(int'(count) % 10);
    end
endmodule

// File: rtl/dec_acc_shifter.sv
// Multi-cycle shifter for a packed-BCD sign-magnitude accumulator.
// Moves one digit per clock; a rounding shift keeps the last digit lost in a
// guard register and adds one when it is 5 or more; normalize counts places
// and writes the count into the two low digits. The sign passes through untouched.
// Assumes shift_digit is BCD (0..9) whenever start is high.
module dec_acc_shifter
    import dsu_pkg::*;
#(
    parameter int NDIG = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_sel,
    input  logic [3:0]        shift_digit,
    input  logic [NDIG*4-1:0] acc_in,
    input  logic              sign_in,
    output logic [NDIG*4-1:0] acc_out,
    output logic              sign_out,
    output logic              done
);
    localparam int AW       = NDIG * 4;
    localparam int CW       = $clog2(NDIG + 1);
    localparam int RND_ZERO = 10;

    shift_state_e   state_q;
    shift_op_e      op_q;
    logic [AW-1:0]  work_q;
    logic [3:0]     guard_q;
    logic           sgn_q;
    logic [CW-1:0]  remain_q;
    logic [CW-1:0]  nrm_cnt_q;

    logic [CW-1:0]  eff_count;
    logic           msd_zero;
    logic           round_up;
    logic [AW-1:0]  rounded;
    logic [7:0]     cnt_bcd;
    logic [AW-1:0]  result;

    // Translate the place digit; a zero digit on the rounding shift means ten places.
    always_comb begin
        if (shift_op_e'(op_sel) == OP_SHR_RND && shift_digit == 4'd0)
            eff_count = CW'(RND_ZERO);
        else
            eff_count = CW'(shift_digit);
    end

    assign msd_zero = (work_q[AW-1 -: 4] == 4'd0);
    assign round_up = (guard_q >= 4'd5);

    dsu_bcd_incr #(.NDIG(NDIG)) u_incr (
        .mag_in  (work_q),
        .cin     (round_up),
        .mag_out (rounded)
    );

    dsu_count_bcd #(.CW(CW)) u_count (
        .count (nrm_cnt_q),
        .bcd   (cnt_bcd)
    );

    // Pick the final magnitude for the operation in flight.
    always_comb begin
        case (op_q)
            OP_SHR_RND:  result = rounded;
            OP_SHL_NORM: result = {work_q[AW-1:8], cnt_bcd};
            default:     result = work_q;
        endcase
    end

    // Sequencer and datapath: load, step one digit per cycle, then publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_SHR;
            work_q    <= '0;
            guard_q   <= '0;
            sgn_q     <= 1'b0;
            remain_q  <= '0;
            nrm_cnt_q <= '0;
            acc_out   <= '0;
            sign_out  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q      <= shift_op_e'(op_sel);
                        work_q    <= acc_in;
                        guard_q   <= '0;
                        sgn_q     <= sign_in;
                        remain_q  <= eff_count;
                        nrm_cnt_q <= '0;
                        state_q   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (op_q == OP_SHL_NORM) begin
                        if (!msd_zero || nrm_cnt_q == CW'(NDIG)) begin
                            state_q <= ST_FINISH;
                        end else begin
                            work_q    <= {work_q[AW-5:0], 4'd0};
                            nrm_cnt_q <= nrm_cnt_q + 1'b1;
                        end
                    end else if (remain_q == '0) begin
                        state_q <= ST_FINISH;
                    end else begin
                        remain_q <= remain_q - 1'b1;
                        if (op_q == OP_SHL) begin
                            work_q <= {work_q[AW-5:0], 4'd0};
                        end else begin
                            guard_q <= work_q[3:0];
                            work_q  <= {4'd0, work_q[AW-1:4]};
                        end
                    end
                end
                ST_FINISH: begin
                    acc_out  <= result;
                    sign_out <= sgn_q;
                    done     <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: completion is a single-cycle pulse.
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: the place digit must be BCD when a request arrives.
    p_bcd_digit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |-> (shift_digit <= 4'd9));

    // R3: shift counts never exceed ten places.
    p_count_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && op_q != OP_SHL_NORM) |-> (remain_q <= CW'(RND_ZERO)));

    // R6: a normalized result with a short count has a nonzero top digit.
    p_norm_msd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_SHL_NORM && nrm_cnt_q != CW'(NDIG)) |-> (acc_out[AW-1 -: 4] != 4'd0));

    // R7: normalize never counts past the accumulator width.
    p_norm_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nrm_cnt_q <= CW'(NDIG));

    // R8: the published sign is the one captured with the request.
    p_sign_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sign_out == sgn_q));

    // R9: a request while busy leaves the captured operation alone.
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(op_q));
endmodule

// File: tb/dec_acc_shifter_test.sv
// Self-checking bench: directed corners plus seeded random operations,
// compared with a loop-based decimal model.
module dec_acc_shifter_test;
    localparam int NDIG = 20;
    localparam int AW   = NDIG * 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [1:0]    op_sel;
    logic [3:0]    shift_digit;
    logic [AW-1:0] acc_in;
    logic          sign_in;
    logic [AW-1:0] acc_out;
    logic          sign_out;
    logic          done;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dec_acc_shifter #(.NDIG(NDIG)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .shift_digit(shift_digit), .acc_in(acc_in), .sign_in(sign_in),
        .acc_out(acc_out), .sign_out(sign_out), .done(done)
    );

    function automatic logic [AW-1:0] model(input int op, input int dig, input logic [AW-1:0] a);
        logic [AW-1:0] r;
        int n;
        int k;
        logic [3:0] g;
        logic cy;
        r = a;
        case (op)
            0: r = a >> (4 * dig);
            2: r = a << (4 * dig);
            1: begin
                n  = (dig == 0) ? 10 : dig;
                r  = a >> (4 * n);
                g  = 4'(a >> (4 * (n - 1)));
                cy = (g >= 4'd5);
                for (int i = 0; i < NDIG; i++) begin
                    if (cy) begin
                        if (r[4*i +: 4] == 4'd9) r[4*i +: 4] = 4'd0;
                        else begin r[4*i +: 4] = r[4*i +: 4] + 4'd1; cy = 1'b0; end
                    end
                end
            end
            default: begin
                k = 0;
                while (k < NDIG && r[AW-1 -: 4] == 4'd0) begin
                    r = r << 4;
                    k++;
                end
                r[7:4] = 4'(k / 10);
                r[3:0] = 4'(k % 10);
            end
        endcase
        return r;
    endfunction

    function automatic logic [AW-1:0] rand_bcd(input int lead_zeros);
        logic [AW-1:0] v;
        v = '0;
        for (int i = 0; i < NDIG - lead_zeros; i++)
            v[4*i +: 4] = 4'($urandom_range(0, 9));
        return v;
    endfunction

    function automatic logic [AW-1:0] fill_digit(input logic [3:0] d);
        logic [AW-1:0] v;
        for (int i = 0; i < NDIG; i++) v[4*i +: 4] = d;
        return v;
    endfunction

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation; optionally fire a second start with other data mid-run.
    task automatic run_op(input string req, input int op, input int dig,
                          input logic [AW-1:0] a, input logic s, input bit poke);
        logic [AW-1:0] exp;
        int w;
        exp = model(op, dig, a);
        @(negedge clk);
        op_sel = 2'(op); shift_digit = 4'(dig); acc_in = a; sign_in = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            op_sel = 2'd2; shift_digit = 4'd3; acc_in = ~a; sign_in = ~s; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 60) begin @(negedge clk); w++; end
        check({req, " done seen"}, AW'(done), AW'(1));
        check({req, " magnitude"}, acc_out, exp);
        check({req, " sign R8"}, AW'(sign_out), AW'(s));
        @(negedge clk);
        check({req, " done pulse R2"}, AW'(done), AW'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; op_sel = '0; shift_digit = '0; acc_in = '0; sign_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset acc", acc_out, '0);
        check("R1 reset sign", AW'(sign_out), '0);
        check("R1 reset done", AW'(done), '0);
        rst_n = 1'b1;

        // R3 plain right: none, max.
        run_op("R3 shr zero", 0, 0, 80'h12345678901234567890, 1'b0, 1'b0);
        run_op("R3 shr nine", 0, 9, 80'h12345678901234567890, 1'b1, 1'b0);
        // R4 plain left: none, max with loss at top.
        run_op("R4 shl zero", 2, 0, 80'h98765432109876543210, 1'b0, 1'b0);
        run_op("R4 shl nine", 2, 9, 80'h98765432109876543210, 1'b1, 1'b0);
        // R5 rounding: zero digit means ten places, long ripple, round down.
        run_op("R5 rnd ten places", 1, 0, 80'h00000000015000000000, 1'b1, 1'b0);
        run_op("R5 rnd ripple nines", 1, 1, fill_digit(4'd9), 1'b0, 1'b0);
        run_op("R5 rnd below half", 1, 3, 80'h00000000000000001499, 1'b1, 1'b0);
        // R6 normalize: already normalized, single one at bottom.
        run_op("R6 norm no shift", 3, 0, 80'h70000000000000000055, 1'b0, 1'b0);
        run_op("R6 norm from one", 3, 5, 80'h00000000000000000001, 1'b1, 1'b0);
        // R7 normalize zero, negative sign kept on zero value (R8).
        run_op("R7 norm zero", 3, 0, '0, 1'b1, 1'b0);
        // R9 second start mid-operation ignored.
        run_op("R9 busy start", 1, 4, 80'h00001234567890123456, 1'b0, 1'b1);
        run_op("R9 busy start norm", 3, 0, 80'h00000000000000000420, 1'b1, 1'b1);

        // R2 operation mix under random operands and leading zeros.
        for (int it = 0; it < 400; it++) begin
            int op;
            int dig;
            op  = $urandom_range(0, 3);
            dig = $urandom_range(0, 9);
            run_op("R2 random", op, dig, rand_bcd($urandom_range(0, NDIG)),
                   1'($urandom_range(0, 1)), (it % 37) == 5);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule